// File: doc/BRIEF.md
# Parallel Port Handshake Controller

This block connects a processor to a peripheral through two parallel ports and a pair of strobe pins. One port is output only. The other is the handshake port: it can latch incoming data, drive outgoing data, or serve as general-purpose I/O one pin at a time. The inbound strobe pin (`straPin`) comes from the peripheral. The outbound strobe pin (`strbPin`) goes to the peripheral. A small register file on a synchronous bus selects the mode, the active edge of the inbound strobe and the polarity of the outbound strobe. The same register file exposes a read-only event flag.

There are three modes.

- **Simple strobe mode** is the mode after reset. Each write to the output port gives a fixed-width pulse on the outbound strobe. Each active inbound edge latches the handshake port and sets the flag.
- **Full-input handshake** keeps the outbound strobe active as a "ready" indication while the latch is empty. A capture drops the indication. A processor read of the latch raises it again.
- **Full-output handshake** drives the handshake port from its output register. A processor write to that register raises a "data valid" indication on the outbound strobe. The peripheral's acknowledging edge on the inbound strobe clears the indication and sets the flag.

The inbound strobe and the handshake-port inputs each pass through two synchronizing flops before they are used.

Top module: `pio_handshake_top`

## Requirements
- R1: After reset the mode is simple strobe, the flag is 0, the inbound active edge is falling, the outbound strobe is active-high and inactive (`strbPin`=0), and every data, direction and output register is 0. A read of the configuration register returns 8'h08.
- R2: The configuration register is at address 0. Its bits are [1:0] mode (00 strobe, 01 full-input, 10 full-output), [2] rising-edge select, [3] active-high outbound strobe and [7] flag (read-only). All other bits read as 0. A write with mode 11 leaves the mode unchanged but still updates bits 2 and 3.
- R3: The inbound strobe and the handshake-port inputs each pass through two flops. The flag is set, and the latch (read at address 2) loads the synchronized port value, on the third rising clock edge after the inbound pin makes its active transition. A transition of the inactive kind does nothing.
- R4: The flag clears on an access (read or write) to address 2 that follows a configuration read made while the flag was set. If an active edge lands in the same cycle as that clearing access, the flag stays set.
- R5: In strobe mode a write to address 1 updates `portBOut` on the next edge and makes the outbound strobe active for exactly 2 cycles.
- R6: In full-input mode the outbound strobe is active while the latch is empty. A capture makes it inactive. A read of address 2 makes it active again. A capture in the same cycle as that read wins, and the strobe stays inactive.
- R7: In full-output mode `portCOe` is all ones. A write to address 2 drives the data and makes the outbound strobe active. An active inbound edge makes it inactive and sets the flag, but no capture takes place. If the write and the edge fall in the same cycle, the strobe stays active.
- R8: In either full-handshake mode a write to address 1 still updates `portBOut` but produces no strobe pulse.
- R9: Outside full-output mode `portCOe` equals the direction register (address 3 write, 1 = drive), and `portCOut` always carries the address 2 output register. A read of address 3 returns the synchronized pin values.
- R10: With bit 3 cleared the outbound strobe is active-low. With bit 2 set, rising inbound edges are the active ones.
- R11: Any configuration write empties the latch, drops the data-valid state and ends a pending pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuSel | input | 1 | Bus access this cycle |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 2 | Register address |
| cpuWdata | input | 8 | Write data |
| cpuRdata | output | 8 | Read data for `cpuAddr` (combinational) |
| straPin | input | 1 | Inbound strobe from peripheral |
| strbPin | output | 1 | Outbound strobe to peripheral |
| portBOut | output | 8 | Output-only port |
| portCIn | input | 8 | Handshake port pin inputs |
| portCOut | output | 8 | Handshake port output data |
| portCOe | output | 8 | Handshake port drive enables |

## Verification
Two kinds of event can land on the same clock edge: a synchronized active strobe edge, and a processor access that undoes what that edge does. In full-input mode that access is the latch read that re-arms "ready". In full-output mode it is the data write that raises "valid". For the flag it is the clearing access.

The bench provokes each collision by changing the strobe pin two falling edges ahead of the bus access, so that the three-flop path and the bus cycle meet on one rising edge. A cycle-level reference model in the bench decides the winner by the stated priorities. It compares the strobe pin, both ports and the read bus on every clock.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    MODE_STROBE   = 2'b00,
    MODE_FULL_IN  = 2'b01,
    MODE_FULL_OUT = 2'b10
  } pioMode_e;

  localparam logic [1:0] ADDR_CFG = 2'd0;
  localparam logic [1:0] ADDR_PB  = 2'd1;
  localparam logic [1:0] ADDR_PC  = 2'd2;
  localparam logic [1:0] ADDR_PIN = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrB;
    logic       wrC;
    logic       wrDdr;
    logic       capture;
    logic       fullOut;
    logic [1:0] rdSel;
  } pioStrobe_t;
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PULSE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWe,
  input  logic [1:0]        cpuAddr,
  input  logic [3:0]        cfgIn,
  input  logic              straPin,
  output pioStrobe_t        ctl,
  output logic [DATA_W-1:0] ctrlByte,
  output logic              strbActive,
  output logic              strbPin
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  pioMode_e         mode;
  logic             edgeRise, activeHigh, flag, clrArm;
  logic             latchFull, outValid;
  logic [CNT_W-1:0] pulseCnt;
  logic [2:0]       straPipe;
  logic             straHit;
  logic             wrCfg, rdCfg, accLatch, rdLatch;

  always_comb begin
    wrCfg    = cpuSel & cpuWe & (cpuAddr == ADDR_CFG);
    rdCfg    = cpuSel & ~cpuWe & (cpuAddr == ADDR_CFG);
    accLatch = cpuSel & (cpuAddr == ADDR_PC);
    rdLatch  = accLatch & ~cpuWe;
  end

  // [1] is the synchronized level, [2] its previous value
  assign straHit = edgeRise ? (straPipe[1] & ~straPipe[2])
                            : (~straPipe[1] & straPipe[2]);

  always_comb begin
    ctl.wrB     = cpuSel & cpuWe & (cpuAddr == ADDR_PB);
    ctl.wrC     = cpuSel & cpuWe & (cpuAddr == ADDR_PC);
    ctl.wrDdr   = cpuSel & cpuWe & (cpuAddr == ADDR_PIN);
    ctl.capture = straHit & (mode != MODE_FULL_OUT);
    ctl.fullOut = (mode == MODE_FULL_OUT);
    ctl.rdSel   = cpuAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      straPipe   <= '0;
      mode       <= MODE_STROBE;
      edgeRise   <= 1'b0;
      activeHigh <= 1'b1;
      flag       <= 1'b0;
      clrArm     <= 1'b0;
    end else begin
      straPipe <= {straPipe[1:0], straPin};
      if (wrCfg) begin
        edgeRise   <= cfgIn[2];
        activeHigh <= cfgIn[3];
        if (cfgIn[1:0] != 2'b11) mode <= pioMode_e'(cfgIn[1:0]);
      end
      if (straHit) flag <= 1'b1;
      else if (clrArm && accLatch) flag <= 1'b0;
      if (accLatch) clrArm <= 1'b0;
      else if (rdCfg && flag) clrArm <= 1'b1;
    end
  end

  // handshake state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt  <= '0;
      latchFull <= 1'b0;
      outValid  <= 1'b0;
    end else if (wrCfg) begin
      pulseCnt  <= '0;
      latchFull <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      if (mode == MODE_STROBE && ctl.wrB) pulseCnt <= CNT_W'(PULSE_CYCLES);
      else if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
      if (mode == MODE_FULL_IN) begin
        if (ctl.capture) latchFull <= 1'b1;
        else if (rdLatch) latchFull <= 1'b0;
      end
      if (mode == MODE_FULL_OUT) begin
        if (ctl.wrC) outValid <= 1'b1;
        else if (straHit) outValid <= 1'b0;
      end
    end
  end

  always_comb begin
    case (mode)
      MODE_FULL_IN:  strbActive = ~latchFull;
      MODE_FULL_OUT: strbActive = outValid;
      default:       strbActive = (pulseCnt != '0);
    endcase
    strbPin  = activeHigh ? strbActive : ~strbActive;
    ctrlByte = {flag, {(DATA_W-5){1'b0}}, activeHigh, edgeRise, mode};
  end
endmodule

// File: rtl/pio_dp.sv
module pio_dp
  import pio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pioStrobe_t        ctl,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] ctrlByte,
  input  logic [DATA_W-1:0] portCIn,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [DATA_W-1:0] portBOut,
  output logic [DATA_W-1:0] portCOut,
  output logic [DATA_W-1:0] portCOe
);
  logic [DATA_W-1:0] cSync1, cSync2, latchQ, bReg, cReg, ddrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cSync1 <= '0;
      cSync2 <= '0;
      latchQ <= '0;
      bReg   <= '0;
      cReg   <= '0;
      ddrReg <= '0;
    end else begin
      cSync1 <= portCIn;
      cSync2 <= cSync1;
      if (ctl.capture) latchQ <= cSync2;
      if (ctl.wrB)     bReg   <= cpuWdata;
      if (ctl.wrC)     cReg   <= cpuWdata;
      if (ctl.wrDdr)   ddrReg <= cpuWdata;
    end
  end

  always_comb begin
    portBOut = bReg;
    portCOut = cReg;
    portCOe  = ctl.fullOut ? '1 : ddrReg;
    case (ctl.rdSel)
      ADDR_CFG: cpuRdata = ctrlByte;
      ADDR_PB:  cpuRdata = bReg;
      ADDR_PC:  cpuRdata = latchQ;
      default:  cpuRdata = cSync2;
    endcase
  end
endmodule

// File: rtl/pio_handshake_top.sv
module pio_handshake_top
  import pio_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PULSE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWe,
  input  logic [1:0]        cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic              straPin,
  output logic              strbPin,
  output logic [DATA_W-1:0] portBOut,
  input  logic [DATA_W-1:0] portCIn,
  output logic [DATA_W-1:0] portCOut,
  output logic [DATA_W-1:0] portCOe
);
  pioStrobe_t        ctlBus;
  logic [DATA_W-1:0] ctrlByte;
  logic              strbActive;

  pio_ctrl #(.DATA_W(DATA_W), .PULSE_CYCLES(PULSE_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cfgIn(cpuWdata[3:0]), .straPin(straPin), .ctl(ctlBus), .ctrlByte(ctrlByte),
    .strbActive(strbActive), .strbPin(strbPin)
  );

  pio_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .cpuWdata(cpuWdata), .ctrlByte(ctrlByte),
    .portCIn(portCIn), .cpuRdata(cpuRdata), .portBOut(portBOut),
    .portCOut(portCOut), .portCOe(portCOe)
  );
endmodule

// File: rtl/pio_handshake_chk.sv
module pio_handshake_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuSel,
  input logic              cpuWe,
  input logic [1:0]        cpuAddr,
  input logic [DATA_W-1:0] cpuWdata,
  input logic [DATA_W-1:0] ctrlByte,
  input logic [DATA_W-1:0] portCOe,
  input logic              strbActive,
  input logic              wrB,
  input logic              wrC,
  input logic              capture
);
  logic       wrCfg;
  logic [1:0] modeNow;
  logic       flagNow;
  assign wrCfg   = cpuSel & cpuWe & (cpuAddr == 2'd0);
  assign modeNow = ctrlByte[1:0];
  assign flagNow = ctrlByte[DATA_W-1];

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!wrCfg || cpuWdata[1:0] == 2'b11) |=> $stable(modeNow));

  assert_flag_on_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> flagNow);

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == 2'b00 && wrB && !wrCfg) |=> strbActive ##1 strbActive);

  assert_capture_not_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == 2'b01 && capture && !wrCfg) |=> !strbActive);

  assert_full_drive_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == 2'b10) |-> (portCOe == '1));

  assert_valid_on_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == 2'b10 && wrC && !wrCfg) |=> strbActive);
endmodule

bind pio_handshake_top pio_handshake_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
  .cpuWdata(cpuWdata), .ctrlByte(ctrlByte), .portCOe(portCOe),
  .strbActive(strbActive), .wrB(ctlBus.wrB), .wrC(ctlBus.wrC),
  .capture(ctlBus.capture)
);

// File: tb/pio_handshake_tb.sv
module pio_handshake_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuSel = 1'b0, cpuWe = 1'b0;
  logic [1:0] cpuAddr = 2'd0;
  logic [7:0] cpuWdata = 8'd0, portCIn = 8'd0;
  logic       straPin = 1'b0;
  logic [7:0] cpuRdata, portBOut, portCOut, portCOe;
  logic       strbPin;

  int    checks = 0, fails = 0;
  string curReq = "R1";
  bit    done = 0;

  always #4 clk = ~clk;

  pio_handshake_top dut_i (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .straPin(straPin), .strbPin(strbPin),
    .portBOut(portBOut), .portCIn(portCIn), .portCOut(portCOut), .portCOe(portCOe)
  );

  // reference model state
  int   mMode, mCnt;
  bit   mEdge, mPol, mFlag, mArm, mFull, mValid;
  bit   s1, s2, s3;
  logic [7:0] c1, c2, mLatch, mB, mC, mDdr;
  bit   hit, oldFlag, wrCfg, rdCfg, accC, rdC, wrCr, wrBr, wrD;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mCnt = 0; mEdge = 0; mPol = 1; mFlag = 0; mArm = 0;
      mFull = 0; mValid = 0; s1 = 0; s2 = 0; s3 = 0;
      c1 = 0; c2 = 0; mLatch = 0; mB = 0; mC = 0; mDdr = 0;
    end else begin
      hit     = mEdge ? (s2 && !s3) : (!s2 && s3);
      oldFlag = mFlag;
      wrCfg = cpuSel && cpuWe && cpuAddr == 0;
      rdCfg = cpuSel && !cpuWe && cpuAddr == 0;
      accC  = cpuSel && cpuAddr == 2;
      rdC   = accC && !cpuWe;
      wrCr  = accC && cpuWe;
      wrBr  = cpuSel && cpuWe && cpuAddr == 1;
      wrD   = cpuSel && cpuWe && cpuAddr == 3;
      if (hit) mFlag = 1; else if (mArm && accC) mFlag = 0;
      if (accC) mArm = 0; else if (rdCfg && oldFlag) mArm = 1;
      if (hit && mMode != 2) mLatch = c2;
      if (wrCfg) begin
        mCnt = 0; mFull = 0; mValid = 0;
      end else begin
        if (mMode == 0 && wrBr) mCnt = 2; else if (mCnt > 0) mCnt--;
        if (mMode == 1) begin
          if (hit) mFull = 1; else if (rdC) mFull = 0;
        end
        if (mMode == 2) begin
          if (wrCr) mValid = 1; else if (hit) mValid = 0;
        end
      end
      if (wrBr) mB = cpuWdata;
      if (wrCr) mC = cpuWdata;
      if (wrD)  mDdr = cpuWdata;
      if (wrCfg) begin
        mEdge = cpuWdata[2]; mPol = cpuWdata[3];
        if (cpuWdata[1:0] != 2'b11) mMode = cpuWdata[1:0];
      end
      s3 = s2; s2 = s1; s1 = straPin;
      c2 = c1; c1 = portCIn;
    end
  end

  task automatic chk(string sig, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", curReq, sig, act, exp, $time);
    end
  endtask

  // compare between posedge and the next negedge drive
  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      bit act;
      logic [7:0] expRd;
      act = (mMode == 1) ? !mFull : (mMode == 2) ? mValid : (mCnt != 0);
      case (cpuAddr)
        2'd0: expRd = {mFlag, 3'b000, mPol, mEdge, mMode[1:0]};
        2'd1: expRd = mB;
        2'd2: expRd = mLatch;
        default: expRd = c2;
      endcase
      chk("strbPin", {7'd0, strbPin}, {7'd0, (mPol ? act : !act)});
      chk("portBOut", portBOut, mB);
      chk("portCOut", portCOut, mC);
      chk("portCOe", portCOe, (mMode == 2) ? 8'hFF : mDdr);
      chk("cpuRdata", cpuRdata, expRd);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic busWr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); cpuSel = 1; cpuWe = 1; cpuAddr = a; cpuWdata = d;
    @(negedge clk); cpuSel = 0; cpuWe = 0;
  endtask
  task automatic busRd(logic [1:0] a);
    @(negedge clk); cpuSel = 1; cpuWe = 0; cpuAddr = a;
    @(negedge clk); cpuSel = 0;
  endtask
  task automatic setStra(logic v);
    @(negedge clk); straPin = v;
  endtask
  task automatic pulseStra();
    setStra(~straPin); idle(3); setStra(~straPin); idle(4);
  endtask

  initial begin
    idle(3); rstN = 1;
    curReq = "R1"; idle(2); busRd(0); idle(1);
    curReq = "R5"; busWr(1, 8'h5A); idle(4); busWr(1, 8'hC3); idle(1);
    curReq = "R3"; portCIn = 8'h3C; setStra(1); idle(4); setStra(0); idle(5);
    busRd(2);
    curReq = "R4"; busRd(0); busRd(2); busRd(0); idle(2);
    portCIn = 8'h71; pulseStra();
    busRd(0);                               // arm clear
    setStra(1); idle(2); setStra(0); idle(1); busRd(2);   // edge meets clear
    busRd(0); busRd(2); busRd(0);
    curReq = "R6"; busWr(0, 8'h09); idle(2);
    portCIn = 8'h96; pulseStra(); busRd(2); idle(2);
    portCIn = 8'h0F; setStra(1); idle(2); setStra(0); idle(1); busRd(2); // collide
    idle(2); busRd(2); idle(2);
    curReq = "R8"; busWr(1, 8'hE1); idle(3);
    curReq = "R11"; pulseStra(); busWr(0, 8'h09); idle(3);
    curReq = "R2"; busWr(0, 8'h0F); busRd(0); idle(1); busWr(0, 8'h0B); busRd(0);
    curReq = "R7"; busWr(0, 8'h0A); idle(2); busWr(2, 8'hC3); idle(2);
    pulseStra(); busRd(0);
    setStra(1); idle(2); setStra(0); idle(1); busWr(2, 8'h44); // collide
    idle(3); busWr(1, 8'h22); idle(3);
    curReq = "R10"; busWr(0, 8'h04); idle(2); busWr(1, 8'h81); idle(4);
    portCIn = 8'hA6; pulseStra(); busRd(2); busRd(0);
    curReq = "R9"; busWr(3, 8'h0F); busWr(2, 8'hA5); portCIn = 8'h5B; idle(3);
    busRd(3); idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog %s: actual hung expected done", curReq);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule